// File: doc/BRIEF.md
# Password-Gated Memory Security Unit

This block keeps protected memory closed until software proves it knows a 128-bit password. The password lives in non-volatile storage as eight 16-bit words and reaches the block as a flat input bus. Software writes eight key words into write-only key registers and then writes a trigger register. One clock later the block compares all eight key words against the stored words. It opens only on a full match.

The block sits beside the memory read path. Each read request carries an address, a source class (secure code, external code or debug port) and the raw memory word. One clock later the block returns a registered verdict and data word. While the block is locked, reads of the protected range are refused when they come from the debug port or from code running outside the secure region. A refused read returns zero. Two stored-password values are special. A password of all zeros can never be opened. A password of all ones marks an erased, unsecured device, which opens by itself. When security is in use, a run of reserved words just below the password area always reads as zero.

Top module: `seclock_unit`

## Requirements
- R1: The reset state is locked: `unlocked_o`=0, `rd_valid_o`=0, `rd_ok_o`=0 and `rd_data_o`=0. Every key word resets to 0xFFFF.
- R2: Key word i is written at config address i (0..7) and compares against `pwd_i[16i+15:16i]`. A write to address 8 (any data) starts a compare. `unlocked_o` takes the result one clock after the edge that captures the trigger write, and it is still unchanged at that capturing edge.
- R3: A compare opens the block only if every key word equals its password word. A mismatch in any single word leaves it locked.
- R4: A failed compare resets all eight key words to 0xFFFF, so words that matched before that compare must be written again.
- R5: If `pwd_i` is all zeros, `unlocked_o` stays 0 whatever keys are written, an all-zero key included.
- R6: If `pwd_i` is all ones, `unlocked_o` becomes 1 one clock after reset ends, with no key write. A relock command has no effect in this case.
- R7: A write to address 9 whose data has bits [15:8]=0xA5 and bit 0=1 relocks the block one clock after the capturing edge and resets the key words to 0xFFFF. A write to address 9 with any other data, or a write to addresses 10 to 15, has no effect.
- R8: Each cycle with `mem_req_i`=1 yields `rd_valid_o`=1 exactly one clock later. A cycle without a request yields `rd_valid_o`=0.
- R9: While locked, a read at an address in 0x8000..0xFFFF is refused (`rd_ok_o`=0, `rd_data_o`=0x0000) when `mem_src_i` is 1 (external code), 2 (debug port) or 3 (unclassified).
- R10: A read of the protected range from `mem_src_i`=0 (secure code), or any read while unlocked, returns `mem_rdata_i` with `rd_ok_o`=1. R11 is the exception to this.
- R11: When `pwd_i` is not all ones, a permitted read in the reserved range 0xFF80..0xFFF5 returns `rd_ok_o`=1 and `rd_data_o`=0x0000. On an erased device, that range passes `mem_rdata_i` unchanged.
- R12: Reads below 0x8000 always pass `mem_rdata_i` with `rd_ok_o`=1, whatever the source and lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwd_i | input | 128 | Stored password, word i at bits [16i+15:16i] |
| cfg_wr_i | input | 1 | Config register write strobe |
| cfg_addr_i | input | 4 | Config register address |
| cfg_wdata_i | input | 16 | Config register write data |
| mem_req_i | input | 1 | Read request to be gated |
| mem_addr_i | input | 16 | Word address of the read |
| mem_src_i | input | 2 | Source class: 0 secure, 1 external code, 2 debug, 3 unclassified |
| mem_rdata_i | input | 16 | Raw memory word for the read |
| unlocked_o | output | 1 | Registered unlocked flag |
| rd_valid_o | output | 1 | Verdict valid, one clock after request |
| rd_ok_o | output | 1 | Read permitted |
| rd_data_o | output | 16 | Gated read data |

## Verification
The gated read verdict and data are due one clock after the request. The bench holds the request across one rising edge and samples at the following falling edge. A compare or relock takes effect one clock after the edge that captures its write. The bench therefore samples once at the falling edge just after that capture, where the old value must remain, and once more a cycle later, where the new value must appear. Erased-device opening follows the first edge after reset is released, and it is sampled at the next falling edge.

// File: rtl/seclock_pkg.sv
package seclock_pkg;

  typedef enum logic [1:0] {
    SRC_SECURE = 2'd0,
    SRC_EXTERN = 2'd1,
    SRC_DEBUG  = 2'd2,
    SRC_OTHER  = 2'd3
  } src_e;

  localparam logic [7:0] RELOCK_TAG = 8'hA5;

endpackage

// File: rtl/seclock_regs.sv
module seclock_regs #(
  parameter int WW = 16,
  parameter int NW = 8,
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [WW-1:0]    wdata,
  input  logic             clr,
  output logic [NW*WW-1:0] key_flat,
  output logic             cmp_go,
  output logic             relock_go
);
  import seclock_pkg::*;

  localparam logic [AW-1:0] CMP_ADDR = AW'(NW);
  localparam logic [AW-1:0] RLK_ADDR = AW'(NW + 1);

  logic [WW-1:0] key_q [NW];

  for (genvar i = 0; i < NW; i++) begin : g_key
    localparam logic [AW-1:0] MY_ADDR = AW'(i);
    always_ff @(posedge clk) begin
      if (rst || clr) key_q[i] <= '1;
      else if (wr && addr == MY_ADDR) key_q[i] <= wdata;
    end
    assign key_flat[i*WW +: WW] = key_q[i];
  end

  logic relock_hit;
  assign relock_hit = wr && (addr == RLK_ADDR) &&
                      (wdata[WW-1 -: 8] == RELOCK_TAG) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_go    <= 1'b0;
      relock_go <= 1'b0;
    end else begin
      cmp_go    <= wr && (addr == CMP_ADDR);
      relock_go <= relock_hit;
    end
  end

  // R4/R7: a clear request wipes every key word on the next edge
  p_keys_cleared_r4: assert property (@(posedge clk) disable iff (rst)
    clr |=> (key_flat == '1));

endmodule

// File: rtl/seclock_compare.sv
module seclock_compare #(
  parameter int WW = 16,
  parameter int NW = 8
) (
  input  logic [NW*WW-1:0] key_flat,
  input  logic [NW*WW-1:0] pwd_flat,
  output logic             match,
  output logic             pwd_zero,
  output logic             pwd_erased
);
  logic [NW-1:0] eq;
  logic [NW-1:0] wz;
  logic [NW-1:0] wo;

  for (genvar i = 0; i < NW; i++) begin : g_word
    assign eq[i] = key_flat[i*WW +: WW] == pwd_flat[i*WW +: WW];
    assign wz[i] = pwd_flat[i*WW +: WW] == '0;
    assign wo[i] = &pwd_flat[i*WW +: WW];
  end

  assign match      = &eq;
  assign pwd_zero   = &wz;
  assign pwd_erased = &wo;

endmodule

// File: rtl/seclock_state.sv
module seclock_state (
  input  logic clk,
  input  logic rst,
  input  logic cmp_go,
  input  logic relock_go,
  input  logic match,
  input  logic pwd_zero,
  input  logic pwd_erased,
  output logic unlocked_q,
  output logic key_clr
);
  logic pass;
  assign pass    = match && !pwd_zero;
  assign key_clr = (cmp_go && !pass) || relock_go;

  always_ff @(posedge clk) begin
    if (rst)             unlocked_q <= 1'b0;
    else if (pwd_erased) unlocked_q <= 1'b1;
    else if (pwd_zero)   unlocked_q <= 1'b0;
    else if (relock_go)  unlocked_q <= 1'b0;
    else if (cmp_go)     unlocked_q <= pass;
  end

  // R5: an all-zero password keeps the lock shut
  p_zero_shut_r5: assert property (@(posedge clk) disable iff (rst)
    pwd_zero |=> !unlocked_q);

  // R6: erased storage opens the block
  p_erased_open_r6: assert property (@(posedge clk) disable iff (rst)
    pwd_erased |=> unlocked_q);

  // R7: relock closes a secured device
  p_relock_r7: assert property (@(posedge clk) disable iff (rst)
    (relock_go && !pwd_erased) |=> !unlocked_q);

  // R2/R3: opening needs a matching compare or erased storage
  p_open_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked_q) |-> ($past(cmp_go && match) || $past(pwd_erased)));

endmodule

// File: rtl/seclock_gate.sv
module seclock_gate #(
  parameter int              WW      = 16,
  parameter int              MAW     = 16,
  parameter logic [MAW-1:0]  PROT_LO = 16'h8000,
  parameter logic [MAW-1:0]  PROT_HI = 16'hFFFF,
  parameter logic [MAW-1:0]  RSV_LO  = 16'hFF80,
  parameter logic [MAW-1:0]  RSV_HI  = 16'hFFF5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req,
  input  logic [MAW-1:0] addr,
  input  logic [1:0]     src,
  input  logic [WW-1:0]  mdata,
  input  logic           unlocked,
  input  logic           secured,
  output logic           rd_valid,
  output logic           rd_ok,
  output logic [WW-1:0]  rd_data
);
  import seclock_pkg::*;

  localparam logic [MAW-1:0] PROT_SPAN = PROT_HI - PROT_LO;
  localparam logic [MAW-1:0] RSV_SPAN  = RSV_HI - RSV_LO;

  logic in_prot, in_rsv, deny;
  logic [MAW-1:0] prot_off, rsv_off;

  assign prot_off = addr - PROT_LO;
  assign rsv_off  = addr - RSV_LO;
  assign in_prot  = prot_off <= PROT_SPAN;
  assign in_rsv   = rsv_off <= RSV_SPAN;
  assign deny     = in_prot && !unlocked && (src != SRC_SECURE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_ok    <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= req;
      if (!req || deny) begin
        rd_ok   <= 1'b0;
        rd_data <= '0;
      end else if (in_rsv && secured) begin
        rd_ok   <= 1'b1;
        rd_data <= '0;
      end else begin
        rd_ok   <= 1'b1;
        rd_data <= mdata;
      end
    end
  end

  // R8: one verdict per request, one clock later
  p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
    req |=> rd_valid);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !req |=> !rd_valid);

  // R9: refused reads carry no data
  p_refuse_blank_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ok) |-> (rd_data == '0));

  // R9: locked foreign access to protected range is refused
  p_foreign_denied_r9: assert property (@(posedge clk) disable iff (rst)
    (req && in_prot && !unlocked && src == SRC_DEBUG) |=> (rd_valid && !rd_ok));

  // R12: unprotected addresses always pass
  p_open_area_r12: assert property (@(posedge clk) disable iff (rst)
    (req && !in_prot) |=> (rd_ok && rd_data == $past(mdata)));

endmodule

// File: rtl/seclock_unit.sv
module seclock_unit #(
  parameter int             WW      = 16,
  parameter int             NW      = 8,
  parameter int             AW      = 4,
  parameter int             MAW     = 16,
  parameter logic [MAW-1:0] PROT_LO = 16'h8000,
  parameter logic [MAW-1:0] PROT_HI = 16'hFFFF,
  parameter logic [MAW-1:0] RSV_LO  = 16'hFF80,
  parameter logic [MAW-1:0] RSV_HI  = 16'hFFF5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NW*WW-1:0] pwd_i,
  input  logic             cfg_wr_i,
  input  logic [AW-1:0]    cfg_addr_i,
  input  logic [WW-1:0]    cfg_wdata_i,
  input  logic             mem_req_i,
  input  logic [MAW-1:0]   mem_addr_i,
  input  logic [1:0]       mem_src_i,
  input  logic [WW-1:0]    mem_rdata_i,
  output logic             unlocked_o,
  output logic             rd_valid_o,
  output logic             rd_ok_o,
  output logic [WW-1:0]    rd_data_o
);
  logic [NW*WW-1:0] key_flat;
  logic cmp_go, relock_go, key_clr;
  logic match, pwd_zero, pwd_erased;

  seclock_regs #(.WW(WW), .NW(NW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr(cfg_wr_i), .addr(cfg_addr_i),
    .wdata(cfg_wdata_i), .clr(key_clr), .key_flat(key_flat),
    .cmp_go(cmp_go), .relock_go(relock_go)
  );

  seclock_compare #(.WW(WW), .NW(NW)) u_cmp (
    .key_flat(key_flat), .pwd_flat(pwd_i), .match(match),
    .pwd_zero(pwd_zero), .pwd_erased(pwd_erased)
  );

  seclock_state u_state (
    .clk(clk), .rst(rst), .cmp_go(cmp_go), .relock_go(relock_go),
    .match(match), .pwd_zero(pwd_zero), .pwd_erased(pwd_erased),
    .unlocked_q(unlocked_o), .key_clr(key_clr)
  );

  seclock_gate #(.WW(WW), .MAW(MAW), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI),
                 .RSV_LO(RSV_LO), .RSV_HI(RSV_HI)) u_gate (
    .clk(clk), .rst(rst), .req(mem_req_i), .addr(mem_addr_i),
    .src(mem_src_i), .mdata(mem_rdata_i), .unlocked(unlocked_o),
    .secured(!pwd_erased), .rd_valid(rd_valid_o), .rd_ok(rd_ok_o),
    .rd_data(rd_data_o)
  );

endmodule

// File: tb/test_seclock_unit.sv
module test_seclock_unit;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] pwd;
  logic         cfg_wr = 1'b0;
  logic [3:0]   cfg_addr = '0;
  logic [15:0]  cfg_wdata = '0;
  logic         mem_req = 1'b0;
  logic [15:0]  mem_addr = '0;
  logic [1:0]   mem_src = '0;
  logic [15:0]  mem_rdata = '0;
  logic         unlocked, rd_valid, rd_ok;
  logic [15:0]  rd_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  seclock_unit i_seclock_unit (
    .clk(clk), .rst(rst), .pwd_i(pwd), .cfg_wr_i(cfg_wr),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .mem_req_i(mem_req),
    .mem_addr_i(mem_addr), .mem_src_i(mem_src), .mem_rdata_i(mem_rdata),
    .unlocked_o(unlocked), .rd_valid_o(rd_valid), .rd_ok_o(rd_ok),
    .rd_data_o(rd_data)
  );

  // {src, addr, data, ok_locked, data_locked, ok_open, data_open}
  localparam int NV = 9;
  localparam logic [67:0] VEC [NV] = '{
    {2'd2, 16'h1000, 16'h1111, 1'b1, 16'h1111, 1'b1, 16'h1111},
    {2'd2, 16'h8000, 16'h2222, 1'b0, 16'h0000, 1'b1, 16'h2222},
    {2'd1, 16'h9ABC, 16'h3333, 1'b0, 16'h0000, 1'b1, 16'h3333},
    {2'd0, 16'h9ABC, 16'h4444, 1'b1, 16'h4444, 1'b1, 16'h4444},
    {2'd0, 16'hFF80, 16'h5555, 1'b1, 16'h0000, 1'b1, 16'h0000},
    {2'd2, 16'hFFF5, 16'h6666, 1'b0, 16'h0000, 1'b1, 16'h0000},
    {2'd2, 16'hFFF6, 16'h7777, 1'b0, 16'h0000, 1'b1, 16'h7777},
    {2'd3, 16'h7FFF, 16'h8888, 1'b1, 16'h8888, 1'b1, 16'h8888},
    {2'd1, 16'hFFFF, 16'h9999, 1'b0, 16'h0000, 1'b1, 16'h9999}
  };

  function automatic logic [15:0] pw_word(int i);
    return 16'hA000 + 16'(i) * 16'h0101;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic reg_write(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic write_keys(int bad_word, logic [15:0] bad_val);
    for (int i = 0; i < 8; i++)
      reg_write(4'(i), (i == bad_word) ? bad_val : pw_word(i));
  endtask

  // trigger a compare and sample one clock after the capturing edge
  task automatic compare_wait();
    reg_write(4'd8, 16'h0000);
    @(negedge clk);
  endtask

  task automatic do_read(logic [1:0] s, logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    mem_req = 1'b1; mem_src = s; mem_addr = a; mem_rdata = d;
    @(negedge clk);
    mem_req = 1'b0;
  endtask

  function automatic string tag_of(logic [1:0] s, logic [15:0] a, bit open);
    if (a < 16'h8000) return "R12";
    if (a >= 16'hFF80 && a <= 16'hFFF5) return "R11";
    if (!open && s != 2'd0) return "R9";
    return "R10";
  endfunction

  task automatic run_table(bit open);
    for (int k = 0; k < NV; k++) begin
      logic [67:0] v;
      v = VEC[k];
      do_read(v[67:66], v[65:50], v[49:34]);
      check("R8 valid", 32'(rd_valid), 32'd1);
      if (!open) begin
        check(tag_of(v[67:66], v[65:50], open), {15'd0, rd_ok, rd_data}, {15'd0, v[33], v[32:17]});
      end else begin
        check(tag_of(v[67:66], v[65:50], open), {15'd0, rd_ok, rd_data}, {15'd0, v[16], v[15:0]});
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) pwd[i*16 +: 16] = pw_word(i);
    do_reset();
    // R1 reset state
    check("R1 unlocked", 32'(unlocked), 32'd0);
    check("R1 rd_valid", {29'd0, rd_valid, rd_ok, 1'b0}, 32'd0);
    check("R1 rd_data", 32'(rd_data), 32'd0);
    // R1 keys reset to ones: a compare against an all-ones word set fails here
    compare_wait();
    check("R1 keys ones no open", 32'(unlocked), 32'd0);

    // locked table pass: R9 R10 R11 R12
    run_table(1'b0);
    @(negedge clk);
    check("R8 idle valid", 32'(rd_valid), 32'd0);

    // R3 single-word mismatch
    write_keys(2, 16'h0BAD);
    compare_wait();
    check("R3 mismatch locked", 32'(unlocked), 32'd0);

    // R4 partial rewrite after a failure must not open
    reg_write(4'd2, pw_word(2));
    compare_wait();
    check("R4 partial keys cleared", 32'(unlocked), 32'd0);

    // R2 full match and timing
    write_keys(-1, 16'h0000);
    reg_write(4'd8, 16'h0000);
    check("R2 not yet at capture edge", 32'(unlocked), 32'd0);
    @(negedge clk);
    check("R2 open one clock later", 32'(unlocked), 32'd1);

    // unlocked table pass: R10 R11 R12
    run_table(1'b1);

    // R7 ignored writes
    reg_write(4'd9, 16'h5A01);
    @(negedge clk);
    check("R7 wrong tag ignored", 32'(unlocked), 32'd1);
    reg_write(4'd9, 16'hA500);
    @(negedge clk);
    check("R7 bit0 clear ignored", 32'(unlocked), 32'd1);
    reg_write(4'd12, 16'hA501);
    @(negedge clk);
    check("R7 other address ignored", 32'(unlocked), 32'd1);
    // R7 proper relock
    reg_write(4'd9, 16'hA501);
    check("R7 still open at capture", 32'(unlocked), 32'd1);
    @(negedge clk);
    check("R7 relocked", 32'(unlocked), 32'd0);
    compare_wait();
    check("R7 keys cleared by relock", 32'(unlocked), 32'd0);
    do_read(2'd2, 16'h8000, 16'h1234);
    check("R9 after relock", {15'd0, rd_ok, rd_data}, 32'd0);

    // R5 zero password
    pwd = '0;
    do_reset();
    write_keys(-1, 16'h0000);
    for (int i = 0; i < 8; i++) reg_write(4'(i), 16'h0000);
    compare_wait();
    check("R5 zero password shut", 32'(unlocked), 32'd0);
    do_read(2'd1, 16'hA000, 16'h4321);
    check("R5 R9 still refused", {15'd0, rd_ok, rd_data}, 32'd0);

    // R6 erased password
    pwd = '1;
    do_reset();
    check("R6 locked in reset", 32'(unlocked), 32'd0);
    @(negedge clk);
    check("R6 opens without key", 32'(unlocked), 32'd1);
    reg_write(4'd9, 16'hA501);
    @(negedge clk);
    check("R6 relock no effect", 32'(unlocked), 32'd1);
    do_read(2'd2, 16'hFF90, 16'hBEEF);
    check("R11 erased passes reserved", {15'd0, rd_ok, rd_data}, {15'd0, 1'b1, 16'hBEEF});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule